// File: doc/BRIEF.md
# Gated 16-Bit Timer/Counter with Selectable Clock Source

This block is a 16-bit up-counter that can count internal time or external events. A 2-bit source code selects what it counts: a quarter-rate instruction tick, every system clock, or rising edges of an external input. When the external source is chosen, a separate select switches from the input pin to a secondary oscillator input. A power-of-two prescaler sits between the source and the counter. Counting is allowed by a run bit, and can also be qualified by a gate input whose polarity is programmable.

Software writes the high and low count bytes directly, and reads the live count. A write clears the prescaler. Each wrap from all ones to zero sets a sticky overflow flag, which software clears with a clear strobe. External edges only count once the counter is armed. Arming takes a falling edge seen after reset, after any count write, or after the run bit was low. The external level can be taken through a two-flop synchronizer, or used directly as sampled on the system clock.

Top module: `gt16_top`

## Requirements
- R1: With run_on=0 the count never advances. With run_on=1 and gate_use=0 it always advances on qualified ticks. With run_on=1 and gate_use=1 it advances only while the gate is active.
- R2: src_sel selects the source. 00 gives one tick per four system clocks, 01 gives one tick per system clock, 10 gives external rising edges and 11 gives no ticks. With code 10 and osc_sel=1, osc_in is counted and ext_pin is ignored.
- R3: pre_sel=k divides source ticks by 2^k (k=0..3). After a prescaler clear, the counter advances on tick numbers 2^k, 2·2^k, and so on. Between writes, the count changes by at most one per cycle.
- R4: Any write to either count byte clears the prescaler count.
- R5: wr_lo loads wr_data into count bits 7:0 and wr_hi loads it into bits 15:8, both on the next clock edge. The other byte is left alone, and a write cycle blocks the increment.
- R6: In external mode, only rising edges advance the count, and only while the counter is armed. A falling edge arms it.
- R7: Reset, any count write, or run_on=0 disarms the external counter. A rising edge after re-enable therefore does not count until a falling edge has been seen.
- R8: A wrap from FFFFh to 0000h sets ovf_flag on the next edge, and the flag stays set.
- R9: flag_clr clears ovf_flag, except in a cycle where a wrap also occurs; then the flag stays set.
- R10: The gate is active when the two-flop-synchronized gate_in equals gate_pol.
- R11: sync_sel=1 passes the external level through a two-flop synchronizer. sync_sel=0 uses the level as sampled on the system clock. Either way, each rising edge counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_on | input | 1 | Timer run bit |
| gate_use | input | 1 | Qualify counting with the gate |
| gate_pol | input | 1 | Gate active level |
| gate_in | input | 1 | Asynchronous gate input |
| src_sel | input | 2 | Clock source code |
| osc_sel | input | 1 | Use osc_in instead of ext_pin in external mode |
| sync_sel | input | 1 | Synchronize the external level |
| ext_pin | input | 1 | External clock pin |
| osc_in | input | 1 | Secondary oscillator input |
| pre_sel | input | 2 | Prescale exponent |
| wr_lo | input | 1 | Write strobe for low count byte |
| wr_hi | input | 1 | Write strobe for high count byte |
| wr_data | input | 8 | Write data byte |
| flag_clr | input | 1 | Clear strobe for overflow flag |
| count_q | output | 16 | Live count value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The overflow set and the software clear of the flag can land in the same cycle. The bench provokes this by loading FFFFh and then enabling one system-clock tick while flag_clr is held high. It judges the result by the count reading 0000h with ovf_flag still set, and by the flag dropping one cycle later once the wrap has passed. A second collision is between a count write and a pending prescaler or arming state. The bench drives a partial prescale, writes, then counts one tick short of a full period and expects no increment.

// File: rtl/gt16_pkg.sv
// Shared types for the gated 16-bit timer.
package gt16_pkg;
    // Clock source codes decoded by the clock selector.
    typedef enum logic [1:0] {
        SRC_INSTR = 2'b00,
        SRC_SYS   = 2'b01,
        SRC_EXT   = 2'b10,
        SRC_NONE  = 2'b11
    } src_e;
endpackage

// File: rtl/gt16_sync.sv
// Multi-flop level synchronizer.
// Assumes the input is a slow level; no pulse stretching is done.
module gt16_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/gt16_clksel.sv
// Source tick generator: instruction divider, system clock, and the
// external edge detector with its falling-edge arming rule.
// Assumes the external input toggles slower than half the system clock.
module gt16_clksel
    import gt16_pkg::*;
#(
    parameter int INSTR_DIV = 4,
    parameter int SYNC_STG  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e src,
    input  logic osc_sel,
    input  logic sync_sel,
    input  logic pin_in,
    input  logic osc_in,
    input  logic run_on,
    input  logic wr_any,
    output logic tick,
    output logic arm_q
);
    localparam int DW = $clog2(INSTR_DIV);

    logic [DW-1:0] div_q;
    logic          ext_raw, ext_s, lvl, prev_q, rise, fall, instr_tick;

    assign ext_raw = osc_sel ? osc_in : pin_in;

    gt16_sync #(.STAGES(SYNC_STG)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d_in(ext_raw), .q_out(ext_s)
    );

    assign lvl  = sync_sel ? ext_s : ext_raw;
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    // Free-running divider for the instruction-rate tick.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end
    assign instr_tick = (div_q == DW'(INSTR_DIV - 1));

    // Remember the previous external level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Arm on a falling edge; disarm on write or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                arm_q <= 1'b0;
        else if (!run_on || wr_any) arm_q <= 1'b0;
        else if (fall)              arm_q <= 1'b1;
    end

    // Select the tick for the chosen source.
    always_comb begin
        unique case (src)
            SRC_INSTR: tick = instr_tick;
            SRC_SYS:   tick = 1'b1;
            SRC_EXT:   tick = rise & arm_q;
            default:   tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/gt16_prescale.sv
// Power-of-two prescaler. The count is cleared by clr, which wins over tick.
// Assumes div_sel never exceeds MAX_LOG.
module gt16_prescale #(
    parameter int MAX_LOG = 3,
    parameter int SW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    input  logic [SW-1:0] div_sel,
    output logic          out_tick,
    output logic [MAX_LOG-1:0] pre_cnt
);
    logic [MAX_LOG-1:0] mask;

    assign mask     = MAX_LOG'((1 << div_sel) - 1);
    assign out_tick = tick & ((pre_cnt & mask) == mask);

    // Count input ticks; clear on software write.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_cnt <= '0;
        else if (clr)  pre_cnt <= '0;
        else if (tick) pre_cnt <= pre_cnt + 1'b1;
    end
endmodule

// File: rtl/gt16_count.sv
// Byte-writable up-counter with wrap pulse. Writes block increments.
// Assumes W is a multiple of 8 and at least 16 (two bytes).
module gt16_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [7:0]   wr_data,
    output logic [W-1:0] cnt_q,
    output logic         wrap
);
    assign wrap = inc & ~wr_lo & ~wr_hi & (&cnt_q);

    // Load bytes on write, otherwise step on increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt_q[7:0]   <= wr_data;
            if (wr_hi) cnt_q[15:8]  <= wr_data;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/gt16_top.sv
// Gated 16-bit timer top: gate qualification, source select, prescaler,
// counter and sticky overflow flag. Single clock, synchronous reset.
module gt16_top
    import gt16_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PRE_LOG  = 3,
    parameter int SYNC_STG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_on,
    input  logic             gate_use,
    input  logic             gate_pol,
    input  logic             gate_in,
    input  logic [1:0]       src_sel,
    input  logic             osc_sel,
    input  logic             sync_sel,
    input  logic             ext_pin,
    input  logic             osc_in,
    input  logic [1:0]       pre_sel,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count_q,
    output logic             ovf_flag
);
    logic gate_s, gate_act, cnt_en, wr_any;
    logic src_tick, arm_q, pre_tick, wrap;
    logic [PRE_LOG-1:0] pre_cnt;

    assign wr_any = wr_lo | wr_hi;

    gt16_sync #(.STAGES(SYNC_STG)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .d_in(gate_in), .q_out(gate_s)
    );

    assign gate_act = (gate_s == gate_pol);
    assign cnt_en   = run_on & (~gate_use | gate_act);

    gt16_clksel #(.INSTR_DIV(4), .SYNC_STG(SYNC_STG)) u_clksel (
        .clk(clk), .rst_n(rst_n), .src(src_e'(src_sel)),
        .osc_sel(osc_sel), .sync_sel(sync_sel),
        .pin_in(ext_pin), .osc_in(osc_in),
        .run_on(run_on), .wr_any(wr_any),
        .tick(src_tick), .arm_q(arm_q)
    );

    gt16_prescale #(.MAX_LOG(PRE_LOG), .SW(2)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(src_tick & cnt_en),
        .clr(wr_any), .div_sel(pre_sel),
        .out_tick(pre_tick), .pre_cnt(pre_cnt)
    );

    gt16_count #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(pre_tick),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .cnt_q(count_q), .wrap(wrap)
    );

    // Sticky overflow flag; a wrap wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (wrap)     ovf_flag <= 1'b1;
        else if (flag_clr) ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/gt16_chk.sv
// Property checker for gt16_top, attached by bind.
module gt16_chk #(
    parameter int CNT_W   = 16,
    parameter int PRE_LOG = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_on,
    input logic [1:0]       src_sel,
    input logic             wr_lo,
    input logic             wr_hi,
    input logic [7:0]       wr_data,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count_q,
    input logic             ovf_flag,
    input logic             wrap,
    input logic             arm_q,
    input logic [PRE_LOG-1:0] pre_cnt
);
    assert_off_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_on && !wr_lo && !wr_hi) |=> $stable(count_q));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=>
        (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));

    assert_pre_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> (pre_cnt == '0));

    assert_low_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (count_q[7:0] == $past(wr_data)));

    assert_unarmed_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b10 && !arm_q && !wr_lo && !wr_hi) |=> $stable(count_q));

    assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_on || wr_lo || wr_hi) |=> !arm_q);

    assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_flag);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !wrap) |=> !ovf_flag);
endmodule

bind gt16_top gt16_chk #(.CNT_W(CNT_W), .PRE_LOG(PRE_LOG)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_on(run_on), .src_sel(src_sel),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .flag_clr(flag_clr),
    .count_q(count_q), .ovf_flag(ovf_flag), .wrap(wrap), .arm_q(arm_q),
    .pre_cnt(pre_cnt)
);

// File: tb/gt16_top_tb.sv
// Self-checking bench for gt16_top: vector table, then directed cases.
module gt16_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_on = 1'b0, gate_use = 1'b0, gate_pol = 1'b1, gate_in = 1'b0;
    logic [1:0]  src_sel = 2'b01, pre_sel = 2'b00;
    logic        osc_sel = 1'b0, sync_sel = 1'b1, ext_pin = 1'b0, osc_in = 1'b0;
    logic        wr_lo = 1'b0, wr_hi = 1'b0, flag_clr = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [15:0] count_q;
    logic        ovf_flag;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    gt16_top u_dut (
        .clk(clk), .rst_n(rst_n), .run_on(run_on), .gate_use(gate_use),
        .gate_pol(gate_pol), .gate_in(gate_in), .src_sel(src_sel),
        .osc_sel(osc_sel), .sync_sel(sync_sel), .ext_pin(ext_pin),
        .osc_in(osc_in), .pre_sel(pre_sel), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .flag_clr(flag_clr), .count_q(count_q),
        .ovf_flag(ovf_flag)
    );

    // Vector fields: {src[1:0], pre[1:0], edges[11:0], expected[15:0]}
    localparam logic [31:0] VEC [0:9] = '{
        {2'b01, 2'd0, 12'd10, 16'd10},
        {2'b01, 2'd1, 12'd10, 16'd5},
        {2'b01, 2'd2, 12'd10, 16'd2},
        {2'b01, 2'd3, 12'd10, 16'd1},
        {2'b01, 2'd3, 12'd17, 16'd2},
        {2'b01, 2'd2, 12'd7,  16'd1},
        {2'b00, 2'd0, 12'd40, 16'd10},
        {2'b00, 2'd1, 12'd40, 16'd5},
        {2'b11, 2'd0, 12'd20, 16'd0},
        {2'b01, 2'd0, 12'd1,  16'd1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr16(input logic [15:0] v);
        run_on = 1'b0;
        wr_hi = 1'b1; wr_data = v[15:8]; step(1);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = v[7:0]; step(1);
        wr_lo = 1'b0;
    endtask

    task automatic run(input int n);
        run_on = 1'b1; step(n); run_on = 1'b0;
    endtask

    task automatic pulse_pin(input logic v);
        ext_pin = v; step(4);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R8 reset count", count_q, 16'h0000);
        chk("R8 reset flag", {15'd0, ovf_flag}, 16'd0);

        // Vector table: source/prescale ratios (R2, R3)
        foreach (VEC[i]) begin
            src_sel = VEC[i][31:30];
            pre_sel = VEC[i][29:28];
            wr16(16'h0000);
            run(int'(VEC[i][27:16]));
            chk($sformatf("R2/R3 vector %0d", i), count_q, VEC[i][15:0]);
        end

        // Direct byte writes (R5)
        src_sel = 2'b01; pre_sel = 2'd0;
        wr16(16'hA55A);
        chk("R5 full write", count_q, 16'hA55A);
        wr16(16'hFFFF);
        wr_hi = 1'b1; wr_data = 8'h12; step(1); wr_hi = 1'b0;
        chk("R5 high byte only", count_q, 16'h12FF);

        // Prescaler clear on write (R4)
        pre_sel = 2'd3;
        wr16(16'h0000); run(5);
        wr16(16'h0000); run(7);
        chk("R4 prescaler cleared", count_q, 16'h0000);
        run(1);
        chk("R4 full period after clear", count_q, 16'h0001);

        // Overflow and sticky flag (R8)
        pre_sel = 2'd0;
        wr16(16'hFFFE); run(2);
        chk("R8 wrap count", count_q, 16'h0000);
        chk("R8 flag set", {15'd0, ovf_flag}, 16'd1);
        step(3);
        chk("R8 flag sticky", {15'd0, ovf_flag}, 16'd1);

        // Set and clear in the same cycle (R9)
        wr16(16'hFFFF);
        flag_clr = 1'b1; run(1);
        chk("R9 wrap with clear count", count_q, 16'h0000);
        chk("R9 set wins over clear", {15'd0, ovf_flag}, 16'd1);
        step(1); flag_clr = 1'b0;
        chk("R9 clear takes effect", {15'd0, ovf_flag}, 16'd0);

        // Gate and run truth table (R1, R10)
        gate_use = 1'b1; gate_pol = 1'b1; gate_in = 1'b0; step(3);
        wr16(16'h0000); run(10);
        chk("R10 gate inactive", count_q, 16'h0000);
        gate_in = 1'b1; step(3); run(10);
        chk("R10 gate active high", count_q, 16'd10);
        gate_pol = 1'b0; run(10);
        chk("R10 polarity inverts gate", count_q, 16'd10);
        gate_use = 1'b0; run(5);
        chk("R1 gate ignored when unused", count_q, 16'd15);
        step(5);
        chk("R1 off holds count", count_q, 16'd15);
        gate_in = 1'b0; gate_pol = 1'b1;

        // External edge counting with arming (R6, R7, R11, R2)
        src_sel = 2'b10; sync_sel = 1'b1; osc_sel = 1'b0; ext_pin = 1'b0;
        step(4);
        wr16(16'h0000); run_on = 1'b1;
        pulse_pin(1'b1);
        chk("R7 rising edge before arming", count_q, 16'd0);
        pulse_pin(1'b0); pulse_pin(1'b1);
        chk("R6 armed rising edge", count_q, 16'd1);
        pulse_pin(1'b0);
        chk("R6 falling edge no count", count_q, 16'd1);
        pulse_pin(1'b1);
        chk("R6 second rising edge", count_q, 16'd2);
        run_on = 1'b0; step(1);
        pulse_pin(1'b0);
        run_on = 1'b1; step(1);
        pulse_pin(1'b1);
        chk("R7 disarmed by stop", count_q, 16'd2);
        pulse_pin(1'b0); pulse_pin(1'b1);
        chk("R7 rearmed after fall", count_q, 16'd3);
        sync_sel = 1'b0;
        pulse_pin(1'b0); pulse_pin(1'b1);
        chk("R11 unsynchronized path", count_q, 16'd4);
        osc_sel = 1'b1; step(4);
        pulse_pin(1'b0); pulse_pin(1'b1);
        chk("R2 pin ignored with osc select", count_q, 16'd4);
        osc_in = 1'b1; step(4);
        chk("R2 osc input counted", count_q, 16'd5);
        osc_in = 1'b0; step(4);
        wr16(16'h0000); run_on = 1'b1;
        osc_in = 1'b1; step(4);
        chk("R7 disarmed by write", count_q, 16'd0);
        run_on = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule